// File: doc/BRIEF.md
# One-Bit Shift and Rotate Unit with Condition Flags

This unit moves an operand by one bit position, or complements it, and reports the outcome as a result word and a four-bit condition code. It serves the shift/rotate slot of a small processor datapath whose native operand sizes are byte, word and longword. The caller presents an operation code, a size select, the operand and the present carry flag together with a one-cycle valid strobe. One clock edge later the result and the packed flags appear on registered outputs, where they stay until the next accepted strobe.

Every size is computed by its own lane. The size select picks one lane. Each operation has its own carry and overflow rule. The two extended rotates take the incoming carry into the vacated bit. Counts of more than one bit, register-file access and instruction decode belong to the surrounding datapath.

Top module: `shrot_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `result_o`, `ccr_o` and `done_o` clear to zero.
- R2: `size_i` selects the operating width: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits. Operand bits above that width are ignored, and `result_o` bits above it are zero.
- R3: Op code 0 (complement) returns the bitwise inverse of the operand at the width, clears V and passes `carry_i` unchanged to C.
- R4: Op codes 1 and 2 (logical left and right) fill the vacated bit with 0, put the bit shifted out into C and clear V.
- R5: Op code 3 (arithmetic left) fills bit 0 with 0 and puts the old MSB into C. It sets V when the two top bits of the operand at the width differ.
- R6: Op code 4 (arithmetic right) keeps the old sign bit in the MSB of the result, puts the old bit 0 into C and clears V.
- R7: Op codes 5 and 6 (plain rotate left and right) wrap the bit shifted out into the vacated end, copy it into C and clear V.
- R8: Op code 7 (rotate left through carry) moves `carry_i` into bit 0 and the old MSB into C. Op code 8 (rotate right through carry) moves `carry_i` into the MSB and the old bit 0 into C. Both clear V.
- R9: N equals the MSB of the result at the selected width. Z is 1 exactly when the result is zero at that width.
- R10: `ccr_o` packs N at bit 3, Z at bit 2, V at bit 1 and C at bit 0.
- R11: An accepted strobe (`valid_i` high with op code 0 to 8) updates `result_o` and `ccr_o` at the next rising edge and raises `done_o` for that one cycle. Without an accepted strobe the outputs hold their values.
- R12: A strobe with op code 9 to 15 is ignored: `result_o` and `ccr_o` hold and `done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Strobe: the inputs below hold an operation |
| op_i | input | 4 | Operation code (0 to 8 defined) |
| size_i | input | 2 | Width select: 0 byte, 1 word, 2/3 longword |
| operand_i | input | 32 | Value to shift, rotate or complement |
| carry_i | input | 1 | Present carry flag |
| result_o | output | 32 | Registered result, zero above the width |
| ccr_o | output | 4 | Registered flags {N,Z,V,C} |
| done_o | output | 1 | High for one cycle after an accepted strobe |

## Verification
The operations are first driven with directed operands whose top two bits differ, agree, or sit at the sign boundary (0x80, 0x40, 0x7F, 0x01, all ones, zero), and with carry in both states. These patterns separate the arithmetic-left overflow from the logical shift, the sign fill from the zero fill, and the plain rotates from the through-carry rotates. Each pattern is repeated at all three widths with garbage in the unused upper operand bits, so that a wrong MSB tap or a leaking upper bit shows up in N, Z or the result. Randomised strobes with idle gaps and illegal op codes mixed in then test the hold behaviour and the one-cycle done pulse against the cycle model.

// File: rtl/shrot_pkg.sv
// Shared types for the one-bit shift/rotate unit.
// Assumes the datapath is a whole number of bytes, up to four lanes of
// doubling width (8, 16, 32, ...).
package shrot_pkg;

    localparam int DATA_W = 32;
    localparam int BASE_W = 8;
    localparam int LANES  = $clog2(DATA_W / BASE_W) + 1;
    localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int CCR_W  = 4;

    // Operation codes; the order is the external encoding.
    typedef enum logic [3:0] {
        OP_NOT   = 4'd0,
        OP_SHLL  = 4'd1,
        OP_SHLR  = 4'd2,
        OP_SHAL  = 4'd3,
        OP_SHAR  = 4'd4,
        OP_ROTL  = 4'd5,
        OP_ROTR  = 4'd6,
        OP_ROTXL = 4'd7,
        OP_ROTXR = 4'd8
    } sr_op_e;

    localparam logic [3:0] OP_LAST = 4'd8;

    // Bit positions inside the packed condition code.
    localparam int CCR_N = 3;
    localparam int CCR_Z = 2;
    localparam int CCR_V = 1;
    localparam int CCR_C = 0;

endpackage

// File: rtl/shrot_lane.sv
// One width lane: applies a single one-bit operation to a W-bit operand
// and derives the carry and overflow that the operation defines.
// Assumes W >= 2. Purely combinational; op codes outside the enum pass
// the operand through (the top never registers them).
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W = 8
) (
    input  sr_op_e         op_i,
    input  logic [W-1:0]   a_i,
    input  logic           cin_i,
    output logic [W-1:0]   res_o,
    output logic           c_o,
    output logic           v_o
);

    logic top_b;
    logic low_b;

    assign top_b = a_i[W-1];
    assign low_b = a_i[0];

    // Result, carry and overflow per operation.
    always_comb begin
        res_o = a_i;
        c_o   = cin_i;
        v_o   = 1'b0;
        case (op_i)
            OP_NOT: begin
                res_o = ~a_i;
            end
            OP_SHLL: begin
                res_o = {a_i[W-2:0], 1'b0};
                c_o   = top_b;
            end
            OP_SHLR: begin
                res_o = {1'b0, a_i[W-1:1]};
                c_o   = low_b;
            end
            OP_SHAL: begin
                res_o = {a_i[W-2:0], 1'b0};
                c_o   = top_b;
                v_o   = a_i[W-1] ^ a_i[W-2];
            end
            OP_SHAR: begin
                res_o = {top_b, a_i[W-1:1]};
                c_o   = low_b;
            end
            OP_ROTL: begin
                res_o = {a_i[W-2:0], top_b};
                c_o   = top_b;
            end
            OP_ROTR: begin
                res_o = {low_b, a_i[W-1:1]};
                c_o   = low_b;
            end
            OP_ROTXL: begin
                res_o = {a_i[W-2:0], cin_i};
                c_o   = top_b;
            end
            OP_ROTXR: begin
                res_o = {cin_i, a_i[W-1:1]};
                c_o   = low_b;
            end
            default: begin
                res_o = a_i;
            end
        endcase
    end

endmodule

// File: rtl/shrot_ccr.sv
// Derives N and Z from a zero-extended result at the selected lane width
// and packs them with V and C into the condition-code nibble.
// Assumes bits above the lane width are already zero.
module shrot_ccr
    import shrot_pkg::*;
(
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              v_i,
    input  logic              c_i,
    output logic [CCR_W-1:0]  ccr_o
);

    logic n_b;
    logic z_b;

    // Sign taken from the top bit of the selected lane.
    always_comb begin
        n_b = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (sel_i == SEL_W'(k)) begin
                n_b = res_i[(BASE_W << k) - 1];
            end
        end
    end

    // Zero test over the full word, valid because upper bits are clear.
    assign z_b = (res_i == '0);

    // Fixed packing of the four flags.
    always_comb begin
        ccr_o        = '0;
        ccr_o[CCR_N] = n_b;
        ccr_o[CCR_Z] = z_b;
        ccr_o[CCR_V] = v_i;
        ccr_o[CCR_C] = c_i;
    end

endmodule

// File: rtl/shrot_unit.sv
// Top of the one-bit shift/rotate unit. Builds one lane per operand size,
// picks the lane named by the size select, forms the flags and registers
// result and flags on an accepted valid strobe.
// Assumes a single clock and a synchronous active-low reset.
module shrot_unit
    import shrot_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [3:0]         op_i,
    input  logic [1:0]         size_i,
    input  logic [DATA_W-1:0]  operand_i,
    input  logic               carry_i,
    output logic [DATA_W-1:0]  result_o,
    output logic [CCR_W-1:0]   ccr_o,
    output logic               done_o
);

    sr_op_e             op_e;
    logic               op_ok;
    logic               accept;
    logic [SEL_W-1:0]   sel;
    logic [DATA_W-1:0]  lane_res [LANES];
    logic [LANES-1:0]   lane_c;
    logic [LANES-1:0]   lane_v;
    logic [DATA_W-1:0]  pick_res;
    logic               pick_c;
    logic               pick_v;
    logic [CCR_W-1:0]   ccr_next;

    assign op_e   = sr_op_e'(op_i);
    assign op_ok  = (op_i <= OP_LAST);
    assign accept = valid_i && op_ok;

    // Size select clamped to the widest lane.
    always_comb begin
        if (int'(size_i) >= LANES - 1) begin
            sel = SEL_W'(LANES - 1);
        end else begin
            sel = SEL_W'(size_i);
        end
    end

    // One lane per operand width, each zero-extended to the datapath.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = BASE_W << g;
        logic [LW-1:0] lres;

        shrot_lane #(.W(LW)) u_lane (
            .op_i  (op_e),
            .a_i   (operand_i[LW-1:0]),
            .cin_i (carry_i),
            .res_o (lres),
            .c_o   (lane_c[g]),
            .v_o   (lane_v[g])
        );

        // Zero-extend this lane's result.
        always_comb begin
            lane_res[g]         = '0;
            lane_res[g][LW-1:0] = lres;
        end
    end

    // Lane multiplexer.
    always_comb begin
        pick_res = '0;
        pick_c   = 1'b0;
        pick_v   = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (sel == SEL_W'(k)) begin
                pick_res = lane_res[k];
                pick_c   = lane_c[k];
                pick_v   = lane_v[k];
            end
        end
    end

    shrot_ccr u_ccr (
        .sel_i (sel),
        .res_i (pick_res),
        .v_i   (pick_v),
        .c_i   (pick_c),
        .ccr_o (ccr_next)
    );

    // Output registers, loaded only on an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            ccr_o    <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= accept;
            if (accept) begin
                result_o <= pick_res;
                ccr_o    <= ccr_next;
            end
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(result_o) && $stable(ccr_o) && !done_o); // R11

    AST_ILLEGAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !op_ok) |=> !done_o); // R12

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && size_i == 2'd0) |=> (result_o[DATA_W-1:BASE_W] == '0)); // R2

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ccr_o[CCR_Z] == (result_o == '0))); // R9

    AST_NOT_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_i == 4'd0) |=> (ccr_o[CCR_C] == $past(carry_i)) && !ccr_o[CCR_V]); // R3

    AST_ROTXL_CIN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_i == 4'd7) |=> (result_o[0] == $past(carry_i))); // R8

    AST_SHLR_NO_V: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_i == 4'd2) |=> !ccr_o[CCR_V]); // R4

endmodule

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;

    logic        clk;
    logic        rst_n;
    logic        valid_i;
    logic [3:0]  op_i;
    logic [1:0]  size_i;
    logic [31:0] operand_i;
    logic        carry_i;
    logic [31:0] result_o;
    logic [3:0]  ccr_o;
    logic        done_o;

    int checks;
    int errors;

    // expected state held by the cycle model
    logic [31:0] exp_res;
    logic [3:0]  exp_ccr;
    logic        exp_done;
    string       exp_tag;
    logic        model_on;

    shrot_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_i),
        .op_i      (op_i),
        .size_i    (size_i),
        .operand_i (operand_i),
        .carry_i   (carry_i),
        .result_o  (result_o),
        .ccr_o     (ccr_o),
        .done_o    (done_o)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic string tag_of(int op);
        case (op)
            0: return "R3";
            1, 2: return "R4";
            3: return "R5";
            4: return "R6";
            5, 6: return "R7";
            7, 8: return "R8";
            default: return "R12";
        endcase
    endfunction

    // behavioural reference: returns {ccr, result}
    function automatic logic [35:0] ref_op(int op, int sz, logic [31:0] a, logic cin);
        int w;
        logic [31:0] mask, am, r;
        logic msb, lsb, c, v, n, z;
        w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
        am  = a & mask;
        msb = am[w-1];
        lsb = am[0];
        v = 1'b0;
        c = cin;
        r = am;
        case (op)
            0: r = ~am & mask;
            1: begin r = (am << 1) & mask; c = msb; end
            2: begin r = am >> 1; c = lsb; end
            3: begin r = (am << 1) & mask; c = msb; v = (msb != am[w-2]); end
            4: begin r = (am >> 1) | (32'(msb) << (w-1)); c = lsb; end
            5: begin r = ((am << 1) | 32'(msb)) & mask; c = msb; end
            6: begin r = (am >> 1) | (32'(lsb) << (w-1)); c = lsb; end
            7: begin r = ((am << 1) | 32'(cin)) & mask; c = msb; end
            8: begin r = (am >> 1) | (32'(cin) << (w-1)); c = lsb; end
            default: r = am;
        endcase
        n = r[w-1];
        z = (r == 0);
        return {n, z, v, c, r};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // cycle model: mirrors the required register behaviour at each edge
    always @(posedge clk) begin
        logic [35:0] m;
        if (!rst_n) begin
            exp_res  = '0;
            exp_ccr  = '0;
            exp_done = 1'b0;
            exp_tag  = "R1";
        end else if (valid_i && op_i <= 4'd8) begin
            m = ref_op(int'(op_i), int'(size_i), operand_i, carry_i);
            exp_res  = m[31:0];
            exp_ccr  = m[35:32];
            exp_done = 1'b1;
            exp_tag  = tag_of(int'(op_i));
        end else begin
            exp_done = 1'b0;
            exp_tag  = (valid_i) ? "R12" : "R11";
        end
    end

    // compare on every cycle away from the active edge
    always @(negedge clk) begin
        if (model_on) begin
            check({exp_tag, " R2 result"}, result_o, exp_res);
            check({exp_tag, " R9 R10 flags"}, 32'(ccr_o), 32'(exp_ccr));
            check({exp_tag, " R11 done"}, 32'(done_o), 32'(exp_done));
        end
    end

    task automatic drive(int op, int sz, logic [31:0] a, logic cin);
        @(negedge clk);
        valid_i   = 1'b1;
        op_i      = 4'(op);
        size_i    = 2'(sz);
        operand_i = a;
        carry_i   = cin;
        @(negedge clk);
        valid_i   = 1'b0;
    endtask

    // directed check of a single accepted op, sampled one edge later
    task automatic expect_op(string req, int op, int sz, logic [31:0] a, logic cin,
                             logic [31:0] er, logic [3:0] ec);
        drive(op, sz, a, cin);
        check({req, " result"}, result_o, er);
        check({req, " flags"}, 32'(ccr_o), 32'(ec));
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        checks = 0;
        errors = 0;
        model_on = 1'b0;
        rst_n = 1'b0;
        valid_i = 1'b0;
        op_i = '0;
        size_i = '0;
        operand_i = '0;
        carry_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 result", result_o, 32'h0);
        check("R1 flags", 32'(ccr_o), 32'h0);
        check("R1 done", 32'(done_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed cases, flags as {N,Z,V,C}
        expect_op("R5 overflow", 3, 0, 32'hFFFF_FF40, 1'b0, 32'h80, 4'b1010);
        expect_op("R5 no overflow", 3, 0, 32'h0000_00C0, 1'b0, 32'h80, 4'b1001);
        expect_op("R4 shll byte", 1, 0, 32'h0000_0080, 1'b0, 32'h00, 4'b0101);
        expect_op("R4 shlr word", 2, 1, 32'hABCD_0001, 1'b0, 32'h0000, 4'b0101);
        expect_op("R6 shar word", 4, 1, 32'h0000_8002, 1'b1, 32'hC001, 4'b1000);
        expect_op("R7 rotl long", 5, 2, 32'h8000_0001, 1'b0, 32'h0000_0003, 4'b0001);
        expect_op("R7 rotr byte", 6, 0, 32'h1234_5601, 1'b0, 32'h80, 4'b1001);
        expect_op("R8 rotxl byte", 7, 0, 32'h0000_0000, 1'b1, 32'h01, 4'b0000);
        expect_op("R8 rotxr long", 8, 3, 32'h0000_0000, 1'b1, 32'h8000_0000, 4'b1000);
        expect_op("R3 not keeps C", 0, 1, 32'hFFFF_FFFF, 1'b1, 32'h0000, 4'b0101);
        expect_op("R2 R9 word msb", 1, 1, 32'hFFFF_4000, 1'b0, 32'h8000, 4'b1000);

        // R12: illegal code ignored, outputs hold
        drive(12, 0, 32'h55, 1'b1);
        check("R12 result hold", result_o, 32'h8000);
        check("R12 done low", 32'(done_o), 32'h0);

        // R11: idle cycles hold
        repeat (2) @(negedge clk);
        check("R11 idle hold", result_o, 32'h8000);

        model_on = 1'b1;
        // sweep all ops, sizes and boundary operands
        for (int op = 0; op < 9; op++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    drive(op, sz, 32'hA5A5_0080, 1'(ci));
                    drive(op, sz, 32'h0000_4000, 1'(ci));
                    drive(op, sz, 32'h7FFF_FFFF, 1'(ci));
                    drive(op, sz, 32'h0000_0001, 1'(ci));
                    drive(op, sz, 32'h0000_0000, 1'(ci));
                end
            end
        end

        // randomised strobes with gaps and illegal codes
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            valid_i   = ($urandom % 4) != 0;
            op_i      = 4'($urandom % 12);
            size_i    = 2'($urandom % 4);
            operand_i = $urandom;
            carry_i   = 1'($urandom % 2);
        end
        @(negedge clk);
        valid_i = 1'b0;
        repeat (3) @(negedge clk);
        model_on = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule